// File: doc/BRIEF.md
# Reconfigurable memory mat

The mat is a single-port storage block of 1024 data words, 32 bits wide. Beside every word sits a 6-bit metadata field held in its own array at the same address. A request port offers three data operations: read, write, and compare of a stored word against a supplied value. Each operation returns its result one cycle after the request. After every accepted access, a loadable update table rewrites the metadata of the word that was touched. The table also drives a 2-bit side channel toward neighbouring mats, and it takes that neighbour's 2 bits as part of its index. This lets a group of mats carry out tag, state or replacement bookkeeping without any controller logic.

A configuration write port sets the mat's role: scratchpad, cache store or FIFO. The same port loads the update table and programs two base/stride pointer pairs. In the FIFO role, reads become pops and writes become pushes on one of two independent queues carved out of the same array. Each queue moves through memory by its own stride, wraps at the top of the array, and rejects overflow and underflow with an error pulse.

Top module: `mat_core`

## Requirements
- R1: Synchronous active-low reset clears rsp_valid, rsp_err, rsp_match and im_out, empties both queues (fifo_empty=2'b11, fifo_full=2'b00), selects the scratchpad role and sets every metadata field to zero.
- R2: An accepted read or write raises rsp_valid on the next cycle with rsp_data equal to the word held before the access; a write also stores req_wdata. req_op encoding: 0 read, 1 write, 2 compare, 3 no-op.
- R3: A compare returns rsp_match=1 exactly when the stored word equals req_wdata, and leaves the data word unchanged.
- R4: rsp_ctrl reports the addressed word's metadata as it was before the access.
- R5: In the cache role (1) and FIFO role (2), every accepted access looks up the table at index {op[1:0], match, metadata[5:0], im_in[1:0]}, where match is 0 for any operation other than compare. It writes entry bits [5:0] back as the word's new metadata and entry bits [7:6] to im_out, which holds until the next such update.
- R6: In the scratchpad role (0, and the spare code 3), accesses leave metadata and im_out unchanged.
- R7: A configuration write with cfg_addr[11]=0 loads table entry cfg_addr[10:0] with cfg_wdata[7:0]; with cfg_addr[11]=1, register number cfg_addr[10:0] selects 0 = role (cfg_wdata[1:0]), 1 = queue 0, 2 = queue 1.
- R8: A queue write takes the base from cfg_wdata[9:0] and the stride from cfg_wdata[19:10], and empties the queue. In the FIFO role, a write pushes to queue req_fsel at its tail and a read pops from its head. Each pointer then advances by the stride modulo 1024. Compare keeps using req_addr.
- R9: Each queue holds at most 8 entries. fifo_full[i] and fifo_empty[i] reflect its occupancy. A push when full or a pop when empty raises rsp_err for one cycle instead of rsp_valid, and changes no data, metadata, pointer or im_out.
- R10: The two queues keep separate pointers, strides and occupancy, so operations on one never disturb the other.
- R11: A no-op request produces neither rsp_valid nor rsp_err and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation code |
| req_addr | input | 10 | Word address (ignored for pushes and pops) |
| req_wdata | input | 32 | Write data or compare value |
| req_fsel | input | 1 | Queue select in the FIFO role |
| im_in | input | 2 | Side-channel bits from a neighbouring mat |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Table index or register number |
| cfg_wdata | input | 20 | Configuration data |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_data | output | 32 | Word before the access |
| rsp_ctrl | output | 6 | Metadata before the access |
| rsp_match | output | 1 | Compare hit |
| rsp_err | output | 1 | Queue overflow or underflow rejection |
| fifo_full | output | 2 | Per-queue full flag |
| fifo_empty | output | 2 | Per-queue empty flag |
| im_out | output | 2 | Side-channel bits to neighbours |

## Verification
Corrupted metadata stays hidden until the next access to that word. It then appears on rsp_ctrl and, through the table, on im_out one cycle after the request. The bench therefore walks repeated accesses to the same addresses, so each update is read back at once. A stray pointer shows on the next pop as wrong data, or as an item out of order. A wrong occupancy count shows on fifo_full or fifo_empty in the cycle after the push or pop that caused it. Both are checked after every single operation.

// File: rtl/mat_pkg.sv
// Shared encodings for the memory mat.
// Assumes two-bit operation and role fields throughout.
package mat_pkg;
    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_WR  = 2'd1,
        OP_CMP = 2'd2,
        OP_NOP = 2'd3
    } mat_op_e;

    typedef enum logic [1:0] {
        ROLE_SCRATCH = 2'd0,
        ROLE_CACHE   = 2'd1,
        ROLE_FIFO    = 2'd2,
        ROLE_SPARE   = 2'd3
    } mat_role_e;

    localparam int OPW = 2;
endpackage

// File: rtl/mat_update_table.sv
// Loadable metadata update table: one entry per combination of operation,
// compare hit, current metadata and incoming side-channel bits.
// Assumes it is loaded before any role that uses it; it has no reset.
module mat_update_table #(
    parameter int IDXW = 11,
    parameter int EW   = 8
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [EW-1:0]   wr_entry,
    input  logic [IDXW-1:0] rd_idx,
    output logic [EW-1:0]   rd_entry
);
    localparam int DEPTH = 1 << IDXW;

    logic [EW-1:0] tbl [DEPTH];

    // Store one entry per configuration write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tbl[wr_idx] <= wr_entry;
        end
    end

    // Lookup is combinational so the update lands in the access cycle.
    assign rd_entry = tbl[rd_idx];
endmodule

// File: rtl/mat_fifo_ptr.sv
// Head/tail pointers, stride and occupancy for one queue inside the mat.
// Assumes push and pop never both arrive in a cycle; load overrides both.
module mat_fifo_ptr #(
    parameter int AW    = 10,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_base,
    input  logic [AW-1:0] load_stride,
    input  logic          push_req,
    input  logic          pop_req,
    output logic [AW-1:0] tail,
    output logic [AW-1:0] head,
    output logic          full,
    output logic          empty
);
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [CNTW-1:0] CNT_MAX = CNTW'(DEPTH);

    logic [AW-1:0]   stride_q;
    logic [AW-1:0]   head_q;
    logic [AW-1:0]   tail_q;
    logic [CNTW-1:0] cnt_q;
    logic            push_ok;
    logic            pop_ok;

    assign full    = (cnt_q == CNT_MAX);
    assign empty   = (cnt_q == '0);
    assign push_ok = push_req && !full;
    assign pop_ok  = pop_req && !empty;
    assign tail    = tail_q;
    assign head    = head_q;

    // Pointer and occupancy update; AW-bit adds wrap at the array size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stride_q <= AW'(1);
            head_q   <= '0;
            tail_q   <= '0;
            cnt_q    <= '0;
        end else if (load) begin
            stride_q <= load_stride;
            head_q   <= load_base;
            tail_q   <= load_base;
            cnt_q    <= '0;
        end else begin
            if (push_ok) tail_q <= tail_q + stride_q;
            if (pop_ok)  head_q <= head_q + stride_q;
            case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + CNTW'(1);
                2'b01:   cnt_q <= cnt_q - CNTW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);

    // R9
    full_push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full && !load) |=> ($stable(cnt_q) && $stable(tail_q)));

    // R9
    empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !load) |=> ($stable(cnt_q) && $stable(head_q)));

    // R8
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !empty && !load) |=> (head_q == $past(head_q) + $past(stride_q)));
endmodule

// File: rtl/mat_core.sv
// Memory mat top: data array, metadata array with table-driven update,
// role register and two stride-driven queues sharing the data array.
// Assumes at most one request per cycle; responses are registered.
module mat_core
    import mat_pkg::*;
#(
    parameter int AW         = 10,
    parameter int DW         = 32,
    parameter int CW         = 6,
    parameter int IW         = 2,
    parameter int NFIFO      = 2,
    parameter int FIFO_DEPTH = 8,
    parameter int CFGW       = 2 * AW,
    localparam int IDXW      = OPW + 1 + CW + IW,
    localparam int CAW       = IDXW + 1,
    localparam int FSW       = (NFIFO > 1) ? $clog2(NFIFO) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [FSW-1:0]   req_fsel,
    input  logic [IW-1:0]    im_in,
    input  logic             cfg_we,
    input  logic [CAW-1:0]   cfg_addr,
    input  logic [CFGW-1:0]  cfg_wdata,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_data,
    output logic [CW-1:0]    rsp_ctrl,
    output logic             rsp_match,
    output logic             rsp_err,
    output logic [NFIFO-1:0] fifo_full,
    output logic [NFIFO-1:0] fifo_empty,
    output logic [IW-1:0]    im_out
);
    localparam int WORDS = 1 << AW;
    localparam int EW    = CW + IW;

    mat_op_e        op_e;
    mat_role_e      role_q;
    logic           role_fifo;
    logic           upd_en;
    logic           cfg_tbl_we;
    logic           cfg_reg_we;
    logic [AW-1:0]  sel_addr;
    logic           reject;
    logic           acc_go;
    logic [DW-1:0]  cur_data;
    logic [CW-1:0]  cur_ctrl;
    logic           cmp_hit;
    logic [IDXW-1:0] tbl_idx;
    logic [EW-1:0]  tbl_entry;

    logic [DW-1:0]  data_mem [WORDS];
    logic [CW-1:0]  ctrl_mem [WORDS];

    logic [NFIFO-1:0] f_load;
    logic [NFIFO-1:0] f_push;
    logic [NFIFO-1:0] f_pop;
    logic [AW-1:0]    f_tail [NFIFO];
    logic [AW-1:0]    f_head [NFIFO];

    assign op_e       = mat_op_e'(req_op);
    assign role_fifo  = (role_q == ROLE_FIFO);
    assign upd_en     = (role_q == ROLE_CACHE) || (role_q == ROLE_FIFO);
    assign cfg_tbl_we = cfg_we && !cfg_addr[CAW-1];
    assign cfg_reg_we = cfg_we && cfg_addr[CAW-1];

    // Role register written at register number 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            role_q <= ROLE_SCRATCH;
        end else if (cfg_reg_we && (cfg_addr[IDXW-1:0] == '0)) begin
            role_q <= mat_role_e'(cfg_wdata[1:0]);
        end
    end

    // One pointer block per queue, programmed at register numbers 1..NFIFO.
    for (genvar g = 0; g < NFIFO; g++) begin : g_fifo
        assign f_load[g] = cfg_reg_we && (cfg_addr[IDXW-1:0] == IDXW'(g + 1));
        assign f_push[g] = req_valid && role_fifo && (op_e == OP_WR) && (req_fsel == FSW'(g));
        assign f_pop[g]  = req_valid && role_fifo && (op_e == OP_RD) && (req_fsel == FSW'(g));

        mat_fifo_ptr #(
            .AW    (AW),
            .DEPTH (FIFO_DEPTH)
        ) u_ptr (
            .clk         (clk),
            .rst_n       (rst_n),
            .load        (f_load[g]),
            .load_base   (cfg_wdata[AW-1:0]),
            .load_stride (cfg_wdata[2*AW-1:AW]),
            .push_req    (f_push[g]),
            .pop_req     (f_pop[g]),
            .tail        (f_tail[g]),
            .head        (f_head[g]),
            .full        (fifo_full[g]),
            .empty       (fifo_empty[g])
        );
    end

    // Pick the effective address and decide whether a queue op is refused.
    always_comb begin
        sel_addr = req_addr;
        reject   = 1'b0;
        if (role_fifo) begin
            if (op_e == OP_WR) begin
                sel_addr = f_tail[req_fsel];
                reject   = fifo_full[req_fsel];
            end else if (op_e == OP_RD) begin
                sel_addr = f_head[req_fsel];
                reject   = fifo_empty[req_fsel];
            end
        end
    end

    assign acc_go   = req_valid && (op_e != OP_NOP) && !reject;
    assign cur_data = data_mem[sel_addr];
    assign cur_ctrl = ctrl_mem[sel_addr];
    assign cmp_hit  = (op_e == OP_CMP) && (cur_data == req_wdata);
    assign tbl_idx  = {req_op, cmp_hit, cur_ctrl, im_in};

    mat_update_table #(
        .IDXW (IDXW),
        .EW   (EW)
    ) u_tbl (
        .clk      (clk),
        .wr_en    (cfg_tbl_we),
        .wr_idx   (cfg_addr[IDXW-1:0]),
        .wr_entry (cfg_wdata[EW-1:0]),
        .rd_idx   (tbl_idx),
        .rd_entry (tbl_entry)
    );

    // Data array write port; the array itself is not reset.
    always_ff @(posedge clk) begin
        if (acc_go && (op_e == OP_WR)) begin
            data_mem[sel_addr] <= req_wdata;
        end
    end

    // Metadata array: cleared by reset, rewritten from the table per access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                ctrl_mem[i] <= '0;
            end
        end else if (acc_go && upd_en) begin
            ctrl_mem[sel_addr] <= tbl_entry[CW-1:0];
        end
    end

    // Registered response and side-channel output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_match <= 1'b0;
            rsp_data  <= '0;
            rsp_ctrl  <= '0;
            im_out    <= '0;
        end else begin
            rsp_valid <= acc_go;
            rsp_err   <= req_valid && reject;
            rsp_match <= acc_go && cmp_hit;
            if (acc_go) begin
                rsp_data <= cur_data;
                rsp_ctrl <= cur_ctrl;
            end
            if (acc_go && upd_en) begin
                im_out <= tbl_entry[EW-1:CW];
            end
        end
    end

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R3
    cmp_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_go && (op_e == OP_CMP)) |=> (data_mem[$past(sel_addr)] == $past(cur_data)));

    // R6
    scratch_im_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !upd_en) |=> $stable(im_out));

    // R11
    nop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (op_e == OP_NOP)) |=> (!rsp_valid && !rsp_err && $stable(im_out)));

    // R9
    reject_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && reject) |=> (rsp_err && $stable(im_out)));
endmodule

// File: tb/sim_mat_core.sv
`timescale 1ns/1ps
module sim_mat_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd3;
    logic [9:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [0:0]  req_fsel = '0;
    logic [1:0]  im_in = '0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [19:0] cfg_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic [5:0]  rsp_ctrl;
    logic        rsp_match;
    logic        rsp_err;
    logic [1:0]  fifo_full;
    logic [1:0]  fifo_empty;
    logic [1:0]  im_out;

    int nchecks = 0;
    int errors  = 0;

    always #4 clk = ~clk;

    mat_core u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_fsel(req_fsel),
        .im_in(im_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ctrl(rsp_ctrl),
        .rsp_match(rsp_match), .rsp_err(rsp_err), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .im_out(im_out)
    );

    // Reference model state
    logic [31:0] m_data [1024];
    bit          m_known [1024];
    logic [5:0]  m_ctrl [1024];
    logic [7:0]  m_tbl [2048];
    logic [1:0]  m_im = '0;
    logic [1:0]  m_role = '0;
    int f_head [2];
    int f_tail [2];
    int f_stride [2];
    int f_cnt [2];

    // Stimulus vectors: {op, addr, wdata, im_in}
    localparam logic [45:0] VEC [14] = '{
        {2'd1, 10'd10,   32'hA5A5_0001, 2'd0},
        {2'd1, 10'd11,   32'h0000_FFFF, 2'd1},
        {2'd0, 10'd10,   32'h0,         2'd2},
        {2'd2, 10'd10,   32'hA5A5_0001, 2'd3},
        {2'd2, 10'd10,   32'hA5A5_0002, 2'd0},
        {2'd0, 10'd11,   32'h0,         2'd1},
        {2'd1, 10'd1023, 32'hDEAD_BEEF, 2'd2},
        {2'd0, 10'd1023, 32'h0,         2'd3},
        {2'd1, 10'd0,    32'h1234_5678, 2'd0},
        {2'd2, 10'd0,    32'h1234_5678, 2'd1},
        {2'd1, 10'd10,   32'h5A5A_5A5A, 2'd2},
        {2'd2, 10'd10,   32'h5A5A_5A5A, 2'd3},
        {2'd0, 10'd10,   32'h0,         2'd0},
        {2'd2, 10'd1023, 32'h0,         2'd1}
    };

    function automatic logic [7:0] tbl_fn(input logic [10:0] idx);
        return (idx[7:0] * 8'd29) ^ {idx[10:8], idx[10:9], 3'b101};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cfg(input logic [11:0] a, input logic [19:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_role(input logic [1:0] r);
        cfg(12'h800, {18'd0, r});
        m_role = r;
    endtask

    task automatic set_queue(input int q, input int base, input int stride);
        cfg(12'h801 + 12'(q), {10'(stride), 10'(base)});
        f_head[q] = base; f_tail[q] = base; f_stride[q] = stride; f_cnt[q] = 0;
    endtask

    // One request; model predicts, then outputs are checked half a cycle after the edge.
    task automatic access(input logic [1:0] op, input logic [9:0] addr, input logic [31:0] wd,
                          input int fsel, input logic [1:0] im);
        bit isf, upd, rej, act, known, mt;
        int ea;
        logic [31:0] ed;
        logic [5:0] ec;
        logic [7:0] e;
        string dtag;
        isf = (m_role == 2'd2);
        upd = (m_role == 2'd1) || (m_role == 2'd2);
        ea = int'(addr); rej = 0;
        if (isf && op == 2'd1) begin
            if (f_cnt[fsel] == 8) rej = 1; else ea = f_tail[fsel];
        end
        if (isf && op == 2'd0) begin
            if (f_cnt[fsel] == 0) rej = 1; else ea = f_head[fsel];
        end
        act   = (op != 2'd3) && !rej;
        ed    = m_data[ea];
        known = m_known[ea];
        ec    = m_ctrl[ea];
        mt    = (op == 2'd2) && known && (ed == wd);
        e     = m_tbl[{op, mt, ec, im}];
        req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
        req_fsel = 1'(fsel); im_in = im;
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'd3;
        if (act) begin
            if (op == 2'd1) begin m_data[ea] = wd; m_known[ea] = 1; end
            if (upd) begin m_ctrl[ea] = e[5:0]; m_im = e[7:6]; end
            if (isf && op == 2'd1) begin
                f_tail[fsel] = (f_tail[fsel] + f_stride[fsel]) % 1024; f_cnt[fsel]++;
            end
            if (isf && op == 2'd0) begin
                f_head[fsel] = (f_head[fsel] + f_stride[fsel]) % 1024; f_cnt[fsel]--;
            end
        end
        dtag = (isf && op != 2'd2) ? "R8" : "R2";
        chk(rsp_valid == act, (op == 2'd3) ? "R11" : (rej ? "R9" : "R2"), "rsp_valid",
            32'(rsp_valid), 32'(act));
        chk(rsp_err == rej, (op == 2'd3) ? "R11" : "R9", "rsp_err", 32'(rsp_err), 32'(rej));
        if (act && known) chk(rsp_data === ed, dtag, "rsp_data", rsp_data, ed);
        if (act) chk(rsp_ctrl === ec, "R4", "rsp_ctrl", 32'(rsp_ctrl), 32'(ec));
        if (act && op == 2'd2) chk(rsp_match == mt, "R3", "rsp_match", 32'(rsp_match), 32'(mt));
        chk(im_out == m_im, upd ? "R5" : "R6", "im_out", 32'(im_out), 32'(m_im));
        for (int i = 0; i < 2; i++) begin
            chk(fifo_full[i] == (f_cnt[i] == 8), isf ? "R10" : "R9", "fifo_full",
                32'(fifo_full[i]), 32'(f_cnt[i] == 8));
            chk(fifo_empty[i] == (f_cnt[i] == 0), isf ? "R10" : "R9", "fifo_empty",
                32'(fifo_empty[i]), 32'(f_cnt[i] == 0));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; nchecks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, nchecks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin m_ctrl[i] = '0; m_known[i] = 0; m_data[i] = '0; end
        for (int q = 0; q < 2; q++) begin f_head[q] = 0; f_tail[q] = 0; f_stride[q] = 1; f_cnt[q] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", 32'(rsp_valid), 0);
        chk(rsp_err == 1'b0, "R1", "rsp_err", 32'(rsp_err), 0);
        chk(im_out == 2'b00, "R1", "im_out", 32'(im_out), 0);
        chk(fifo_empty == 2'b11, "R1", "fifo_empty", 32'(fifo_empty), 3);
        chk(fifo_full == 2'b00, "R1", "fifo_full", 32'(fifo_full), 0);

        // R7 load every table entry through the configuration port
        for (int i = 0; i < 2048; i++) begin
            m_tbl[i] = tbl_fn(11'(i));
            cfg(12'(i), {12'd0, m_tbl[i]});
        end

        // R6 scratchpad role (R1: metadata reads back as zero)
        access(2'd1, 10'd5, 32'hCAFE_0005, 0, 2'd3);
        access(2'd0, 10'd5, 32'h0, 0, 2'd1);
        chk(rsp_ctrl == 6'd0, "R1", "metadata after reset", 32'(rsp_ctrl), 0);
        access(2'd2, 10'd5, 32'hCAFE_0005, 0, 2'd2);

        // Cache role: walk the vector table
        set_role(2'd1);
        for (int v = 0; v < 14; v++) begin
            access(VEC[v][45:44], VEC[v][43:34], VEC[v][33:2], 0, VEC[v][1:0]);
        end

        // R7 overwrite one entry and hit it
        begin
            logic [10:0] idx;
            idx = {2'd0, 1'b0, m_ctrl[10], 2'd0};
            m_tbl[idx] = 8'hC5;
            cfg({1'b0, idx}, 20'h000C5);
            access(2'd0, 10'd10, 32'h0, 0, 2'd0);
            chk(im_out == 2'b11, "R7", "im_out from loaded entry", 32'(im_out), 3);
            access(2'd0, 10'd10, 32'h0, 0, 2'd1);
            chk(rsp_ctrl == 6'h05, "R7", "metadata from loaded entry", 32'(rsp_ctrl), 5);
        end

        // R11 no-op leaves state alone
        access(2'd3, 10'd10, 32'h0, 0, 2'd2);
        access(2'd0, 10'd10, 32'h0, 0, 2'd2);

        // FIFO role
        set_role(2'd2);
        set_queue(0, 100, 3);
        set_queue(1, 1020, 5);
        access(2'd0, 10'd0, 32'h0, 0, 2'd0);          // R9 pop when empty
        for (int i = 0; i < 8; i++) access(2'd1, 10'd0, 32'h1000 + 32'(i), 0, 2'(i));
        access(2'd1, 10'd0, 32'hBAD0_0000, 0, 2'd1);  // R9 push when full
        for (int i = 0; i < 3; i++) access(2'd1, 10'd0, 32'h2000 + 32'(i), 1, 2'(i));
        access(2'd2, 10'd100, 32'h1000, 0, 2'd1);     // R8 compare uses req_addr
        for (int i = 0; i < 8; i++) access(2'd0, 10'd0, 32'h0, 0, 2'(i));
        access(2'd0, 10'd0, 32'h0, 0, 2'd3);          // R9 pop when empty again
        access(2'd0, 10'd0, 32'h0, 1, 2'd0);          // R10 queue 1 unaffected
        access(2'd3, 10'd0, 32'h0, 1, 2'd0);          // R11

        // R8 wrap: second push of queue 1 landed at (1020+5) mod 1024 = 1
        set_role(2'd1);
        access(2'd0, 10'd1, 32'h0, 0, 2'd0);
        chk(rsp_data == 32'h2001, "R8", "wrapped address contents", rsp_data, 32'h2001);

        $display("Result: errors=%0d of %0d checks", errors, nchecks);
        $finish;
    end
endmodule